// File: doc/BRIEF.md
# Top-Relative Floating-Point Register Stack

This block holds the eight 80-bit operand registers of a floating-point unit. The registers form a circular stack under a 3-bit top pointer. Every access names a register by its distance from the current top: ST(0) is the top and ST(i) is physical entry (top + i) mod 8. The block takes one command per cycle. A command can push a value, pop the top, write back a result, or exchange the top with another entry. Two read ports give the operands of an operation in the same cycle.

The surrounding unit does the decoding and the arithmetic.
- A unary operation reads ST(0) and writes its result back to ST(0).
- A binary operation reads ST(0) together with ST(1), or with any chosen ST(i). A direction bit on the writeback sends the result to ST(0) or to ST(i), and the other register keeps its value.
- A writeback can also pop in the same cycle.

Each entry has a valid tag. Pushing onto a valid entry reports overflow. Popping, exchanging or reading an empty entry reports underflow.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset, top_o is 0, both fault flags are 0 and all eight entries are empty, so a first pop reports underflow.
- R2: cmd_i=1 (push) onto an empty entry moves top_o to (top-1) mod 8 and stores data_i as the new ST(0). The previous ST(0) becomes ST(1).
- R3: A push whose target entry ST(7) is valid raises overflow_o. It leaves the pointer, the data and the tags unchanged.
- R4: cmd_i=2 (pop) with a valid ST(0) marks that entry empty and moves top_o to (top+1) mod 8, so the old ST(1) becomes ST(0).
- R5: Underflow is raised in three cases: a pop of an empty ST(0), which changes nothing; an enabled read (rd_a_en_i for ST(0), rd_b_en_i for ST(rd_sel_i)) of an empty entry; and an exchange that involves an empty entry.
- R6: rd_a_o always shows ST(0). rd_b_o always shows ST(rd_sel_i), and both ports are combinational.
- R7: cmd_i=3 (write) stores data_i and marks the target valid. With dir_i=0 the target is ST(0); with dir_i=1 it is ST(sel_i). No other entry changes.
- R8: A write with wr_pop_i=1 commits the write and then pops, in the same cycle. The old top ends empty and top_o advances by one.
- R9: cmd_i=4 (exchange) swaps the values and tags of ST(0) and ST(sel_i) in one cycle, and top_o stays unchanged.
- R10: Fault flags are registered and appear in the cycle after the command. They drop to 0 after a cycle with cmd_i=0 (no-op) and no read enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | 0 no-op, 1 push, 2 pop, 3 write, 4 exchange |
| sel_i | input | 3 | Offset i of ST(i) for write (dir_i=1) and exchange |
| dir_i | input | 1 | Write target: 0 = ST(0), 1 = ST(sel_i) |
| wr_pop_i | input | 1 | Pop after the write |
| data_i | input | 80 | Push or write value |
| rd_sel_i | input | 3 | Offset of the second read operand |
| rd_a_en_i | input | 1 | Read of ST(0) counts for underflow |
| rd_b_en_i | input | 1 | Read of ST(rd_sel_i) counts for underflow |
| rd_a_o | output | 80 | Value of ST(0) |
| rd_b_o | output | 80 | Value of ST(rd_sel_i) |
| top_o | output | 3 | Physical top pointer |
| overflow_o | output | 1 | Overflow pulse |
| underflow_o | output | 1 | Underflow pulse |

## Verification
A wrong top pointer shows on top_o one cycle after the command that moved it. It also shifts every value on rd_a_o and rd_b_o at once. A corrupted entry or a swap that goes wrong shows as soon as rd_b_o is steered to that offset. The bench therefore sweeps rd_sel_i after every command. A wrong tag is invisible until a later push, pop, exchange or enabled read, and then it shows as an overflow or underflow pulse one cycle later. Random sequences that wrap the pointer are meant to expose such latent tag errors.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_PUSH  = 3'd1,
    CMD_POP   = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_XCHG  = 3'd4
  } cmd_e;
endpackage

// File: rtl/fpstk_addr.sv
module fpstk_addr #(
  parameter int unsigned PW = 3,
  parameter int unsigned N  = 3
) (
  input  logic [PW-1:0]         top_i,
  input  logic [N-1:0][PW-1:0]  off_i,
  output logic [N-1:0][PW-1:0]  phys_o
);
  for (genvar k = 0; k < N; k++) begin : g_map
    assign phys_o[k] = top_i + off_i[k]; // wraps mod 2**PW
  end
endmodule

// File: rtl/fpstk_regs.sv
module fpstk_regs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 80,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_a_i,
  input  logic [PW-1:0]               idx_a_i,
  input  logic [W-1:0]                din_a_i,
  input  logic                        tin_a_i,
  input  logic                        we_b_i,
  input  logic [PW-1:0]               idx_b_i,
  input  logic [W-1:0]                din_b_i,
  input  logic                        tin_b_i,
  input  logic                        clr_i,
  input  logic [PW-1:0]               clr_idx_i,
  output logic [DEPTH-1:0][W-1:0]     data_o,
  output logic [DEPTH-1:0]            tag_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    // order matters: clear after writes so write+pop leaves the entry empty
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[e] <= '0;
        tag_o[e]  <= 1'b0;
      end else begin
        if (we_a_i && idx_a_i == PW'(e)) begin
          data_o[e] <= din_a_i;
          tag_o[e]  <= tin_a_i;
        end
        if (we_b_i && idx_b_i == PW'(e)) begin
          data_o[e] <= din_b_i;
          tag_o[e]  <= tin_b_i;
        end
        if (clr_i && clr_idx_i == PW'(e)) tag_o[e] <= 1'b0;
      end
    end
  end

  p_popped_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tag_o[$past(clr_idx_i)]);
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 80,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2:0]               cmd_i,
  input  logic                     dir_i,
  input  logic                     wr_pop_i,
  input  logic [W-1:0]             data_i,
  input  logic                     rd_a_en_i,
  input  logic                     rd_b_en_i,
  input  logic [PW-1:0]            p_sel_i,
  input  logic [PW-1:0]            p_rd_i,
  input  logic [PW-1:0]            p_dn_i,
  input  logic [DEPTH-1:0][W-1:0]  data_q_i,
  input  logic [DEPTH-1:0]         tag_q_i,
  output logic [PW-1:0]            top_o,
  output logic                     we_a_o,
  output logic [PW-1:0]            idx_a_o,
  output logic [W-1:0]             din_a_o,
  output logic                     tin_a_o,
  output logic                     we_b_o,
  output logic [PW-1:0]            idx_b_o,
  output logic [W-1:0]             din_b_o,
  output logic                     tin_b_o,
  output logic                     clr_o,
  output logic [PW-1:0]            clr_idx_o,
  output logic                     ovf_o,
  output logic                     uf_o
);
  logic [PW-1:0] top_q, top_d;
  logic          ovf_d, uf_d, t0, ts, tr, tdn;

  assign t0  = tag_q_i[top_q];
  assign ts  = tag_q_i[p_sel_i];
  assign tr  = tag_q_i[p_rd_i];
  assign tdn = tag_q_i[p_dn_i];

  always_comb begin
    top_d     = top_q;
    we_a_o    = 1'b0;
    idx_a_o   = top_q;
    din_a_o   = data_i;
    tin_a_o   = 1'b1;
    we_b_o    = 1'b0;
    idx_b_o   = p_sel_i;
    din_b_o   = data_q_i[top_q];
    tin_b_o   = t0;
    clr_o     = 1'b0;
    clr_idx_o = top_q;
    ovf_d     = 1'b0;
    uf_d      = (rd_a_en_i && !t0) || (rd_b_en_i && !tr);
    unique case (cmd_i)
      CMD_PUSH: begin
        if (tdn) ovf_d = 1'b1;
        else begin
          we_a_o  = 1'b1;
          idx_a_o = p_dn_i;
          top_d   = p_dn_i;
        end
      end
      CMD_POP: begin
        if (!t0) uf_d = 1'b1;
        else begin
          clr_o = 1'b1;
          top_d = top_q + PW'(1);
        end
      end
      CMD_WRITE: begin
        we_a_o  = 1'b1;
        idx_a_o = dir_i ? p_sel_i : top_q;
        if (wr_pop_i) begin
          clr_o = 1'b1;
          top_d = top_q + PW'(1);
        end
      end
      CMD_XCHG: begin
        we_a_o  = 1'b1;
        din_a_o = data_q_i[p_sel_i];
        tin_a_o = ts;
        we_b_o  = 1'b1;
        if (!t0 || !ts) uf_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      ovf_o <= 1'b0;
      uf_o  <= 1'b0;
    end else begin
      top_q <= top_d;
      ovf_o <= ovf_d;
      uf_o  <= uf_d;
    end
  end

  assign top_o = top_q;

  p_push_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PUSH && !tdn) |=> top_q == $past(top_q) - PW'(1));
  p_ovf_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PUSH && tdn) |=> (ovf_o && $stable(top_q)));
  p_pop_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_POP && t0) |=> top_q == $past(top_q) + PW'(1));
  p_uf_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_POP && !t0) |=> (uf_o && $stable(top_q)));
  p_xchg_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_XCHG) |=> $stable(top_q));
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NOP && !rd_a_en_i && !rd_b_en_i) |=> (!ovf_o && !uf_o));
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 80,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [PW-1:0] sel_i,
  input  logic          dir_i,
  input  logic          wr_pop_i,
  input  logic [W-1:0]  data_i,
  input  logic [PW-1:0] rd_sel_i,
  input  logic          rd_a_en_i,
  input  logic          rd_b_en_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  output logic [PW-1:0] top_o,
  output logic          overflow_o,
  output logic          underflow_o
);
  localparam int unsigned NMAP = 3;

  logic [DEPTH-1:0][W-1:0] data_q;
  logic [DEPTH-1:0]        tag_q;
  logic [NMAP-1:0][PW-1:0] offs, phys;
  logic                    we_a, we_b, tin_a, tin_b, clr;
  logic [PW-1:0]           idx_a, idx_b, clr_idx, top;
  logic [W-1:0]            din_a, din_b;

  // offsets: [0] write/exchange target, [1] second read, [2] push slot (top-1)
  assign offs = {PW'(DEPTH-1), rd_sel_i, sel_i};

  fpstk_addr #(.PW(PW), .N(NMAP)) u_addr (
    .top_i(top), .off_i(offs), .phys_o(phys)
  );

  fpstk_ctrl #(.DEPTH(DEPTH), .W(W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_i, .dir_i, .wr_pop_i, .data_i, .rd_a_en_i, .rd_b_en_i,
    .p_sel_i(phys[0]), .p_rd_i(phys[1]), .p_dn_i(phys[2]),
    .data_q_i(data_q), .tag_q_i(tag_q), .top_o(top),
    .we_a_o(we_a), .idx_a_o(idx_a), .din_a_o(din_a), .tin_a_o(tin_a),
    .we_b_o(we_b), .idx_b_o(idx_b), .din_b_o(din_b), .tin_b_o(tin_b),
    .clr_o(clr), .clr_idx_o(clr_idx), .ovf_o(overflow_o), .uf_o(underflow_o)
  );

  fpstk_regs #(.DEPTH(DEPTH), .W(W)) u_regs (
    .clk_i, .rst_ni,
    .we_a_i(we_a), .idx_a_i(idx_a), .din_a_i(din_a), .tin_a_i(tin_a),
    .we_b_i(we_b), .idx_b_i(idx_b), .din_b_i(din_b), .tin_b_i(tin_b),
    .clr_i(clr), .clr_idx_i(clr_idx), .data_o(data_q), .tag_o(tag_q)
  );

  assign rd_a_o = data_q[top];
  assign rd_b_o = data_q[phys[1]];
  assign top_o  = top;
endmodule

// File: tb/fp_reg_stack_tb.sv
module fp_reg_stack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0, sel = 3'd0, rd_sel = 3'd0;
  logic        dir = 1'b0, wr_pop = 1'b0, ra = 1'b0, rb = 1'b0;
  logic [79:0] din = '0;
  logic [79:0] rd_a, rd_b;
  logic [2:0]  top;
  logic        ovf, uf;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [79:0] mv[8];
  bit          mt[8];
  int          mtop;

  always #10 clk = ~clk;

  fp_reg_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .sel_i(sel), .dir_i(dir),
    .wr_pop_i(wr_pop), .data_i(din), .rd_sel_i(rd_sel), .rd_a_en_i(ra),
    .rd_b_en_i(rb), .rd_a_o(rd_a), .rd_b_o(rd_b), .top_o(top),
    .overflow_o(ovf), .underflow_o(uf)
  );

  function automatic int ph(int i);
    return (mtop + i) % 8;
  endfunction

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one command at a negedge, check the result at the next negedge
  task automatic step(int c, int s, bit d, bit wp, logic [79:0] v, int rs,
                      bit ea, bit eb, string req);
    bit eo = 0, eu;
    int a, b, n;
    logic [79:0] tv;
    bit tt;
    eu = (ea && !mt[ph(0)]) || (eb && !mt[ph(rs)]);
    case (c)
      1: begin n = ph(7);
           if (mt[n]) eo = 1; else begin mtop = n; mv[n] = v; mt[n] = 1; end end
      2: if (!mt[ph(0)]) eu = 1;
         else begin mt[ph(0)] = 0; mtop = (mtop + 1) % 8; end
      3: begin a = ph(0); n = d ? ph(s) : a; mv[n] = v; mt[n] = 1;
           if (wp) begin mt[a] = 0; mtop = (mtop + 1) % 8; end end
      4: begin a = ph(0); b = ph(s);
           if (!mt[a] || !mt[b]) eu = 1;
           tv = mv[a]; mv[a] = mv[b]; mv[b] = tv;
           tt = mt[a]; mt[a] = mt[b]; mt[b] = tt; end
      default: ;
    endcase
    cmd = 3'(c); sel = 3'(s); dir = d; wr_pop = wp; din = v;
    rd_sel = 3'(rs); ra = ea; rb = eb;
    @(posedge clk); @(negedge clk);
    cmd = 3'd0; ra = 1'b0; rb = 1'b0;
    chk(top == 3'(mtop), req, "top", 80'(top), 80'(mtop));
    chk(ovf == eo, req, "overflow", 80'(ovf), 80'(eo));
    chk(uf == eu, req, "underflow", 80'(uf), 80'(eu));
    chk(rd_a == mv[ph(0)], req, "ST0 R6", rd_a, mv[ph(0)]);
    n = $urandom_range(7);
    rd_sel = 3'(n); #1;
    chk(rd_b == mv[ph(n)], req, "STi R6", rd_b, mv[ph(n)]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin mv[i] = '0; mt[i] = 0; end
    mtop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(top == 3'd0, "R1", "top", 80'(top), 80'd0);
    chk(!ovf && !uf, "R1", "flags", 80'({ovf, uf}), 80'd0);
    step(2, 0, 0, 0, '0, 0, 0, 0, "R1 R5 pop empty");
    // R2 fill all eight, R3 ninth push overflows
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, rnd80(), 1, 0, 0, "R2 push");
    step(1, 0, 0, 0, rnd80(), 0, 0, 0, "R3 push full");
    step(0, 0, 0, 0, '0, 0, 0, 0, "R10 quiet");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, '0, i, 1, 1, "R6 read sweep");
    step(3, 3, 0, 0, rnd80(), 0, 0, 0, "R7 write ST0");
    step(3, 3, 1, 0, rnd80(), 3, 0, 0, "R7 write STi");
    step(4, 5, 0, 0, '0, 5, 0, 0, "R9 xchg");
    step(4, 0, 0, 0, '0, 0, 0, 0, "R9 xchg self");
    step(3, 2, 1, 1, rnd80(), 1, 1, 1, "R8 write pop");
    step(3, 0, 0, 1, rnd80(), 0, 0, 0, "R8 write pop top");
    step(2, 0, 0, 0, '0, 0, 0, 0, "R4 pop");
    step(0, 0, 0, 0, '0, 7, 0, 1, "R5 read empty");
    step(4, 7, 0, 0, '0, 0, 0, 0, "R5 xchg empty");
    step(0, 0, 0, 0, '0, 0, 0, 0, "R10 flags clear");
    for (int i = 0; i < 600; i++) begin
      int c, w;
      string r;
      w = $urandom_range(9);
      c = (w < 3) ? 1 : (w < 5) ? 2 : (w < 7) ? 3 : (w < 9) ? 4 : 0;
      r = (c == 1) ? "R2 R3" : (c == 2) ? "R4 R5" : (c == 3) ? "R7 R8" :
          (c == 4) ? "R9 R5" : "R10";
      step(c, $urandom_range(7), 1'($urandom_range(1)), 1'($urandom_range(1)),
           rnd80(), $urandom_range(7), 1'($urandom_range(1)),
           1'($urandom_range(1)), r);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule